// File: doc/BRIEF.md
# Multiplier-Free Symmetric FIR Filter (Bit-Serial Table Lookup)

This block is a 32-tap, order-31 linear-phase FIR filter that uses no multipliers. Each accepted sample enters a 32-deep delay line. Because the coefficient set is mirror-symmetric, the two samples that share a coefficient are added first. That leaves 16 pre-added sums, each sign-extended to 17 bits.

The sums are then consumed one bit position per clock, least significant bit first. In each cycle the current bit of all 16 sums forms the addresses of three constant tables: one covering 6 coefficients (64 entries) and two covering 5 coefficients each (32 entries). Each table entry is the sum of the coefficients whose address bits are set. The three table outputs are added, and a shift-accumulator folds that total into the running result. On the sign-bit cycle the total is subtracted instead of added. After 17 cycles the full-precision result is presented with a one-cycle valid strobe.

The coefficients are one packed parameter, and the table contents are computed from it when the design is elaborated. The block accepts a new sample only while it is idle. A sample offered while a computation is running is dropped.

Top module: `da_symfir`

## Requirements
- R1: When a computation finishes, `out_data` equals the exact sum over k=0..15 of h[k]·(x[n−k] + x[n−31+k]). Here x[n] is the most recently accepted sample, x values are signed 16-bit, and h[k] is the signed 12-bit field `COEFS[k*12 +: 12]`. Samples older than 32 acceptances do not contribute.
- R2: Suppose a sample is accepted at rising edge E, meaning `in_valid` and `in_ready` are both high before E. Then `out_valid` is high for the cycle that follows edge E+17, and low in every cycle between.
- R3: `out_valid` is high for exactly one cycle per accepted sample.
- R4: `in_ready` is low from the edge that accepts a sample until the result is presented. A sample offered while `in_ready` is low never enters the delay line and has no effect on any result.
- R5: `in_ready` is high in the cycle in which `out_valid` is high, so a new sample can be accepted in that same cycle.
- R6: A synchronous active-high `rst` clears the delay line to zero, drives `out_valid` low and `in_ready` high, and abandons any running computation without producing a result.
- R7: Full-scale inputs, including −32768, give the exact result with no overflow. This includes inputs whose signs line up with the coefficient signs to reach the largest output magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is offered on `in_data` |
| in_data | input | DATA_W (16) | Signed input sample |
| in_ready | output | 1 | High when idle; a sample is accepted when this and `in_valid` are high |
| out_valid | output | 1 | One-cycle strobe marking `out_data` as a finished result |
| out_data | output | ACC_W (34) | Signed full-precision filter output |

## Verification
The hardest case to reach from the ports is the largest output magnitude. Reaching it needs all 32 delay-line entries to carry full-scale values whose signs match the coefficient signs at both mirrored positions, so the accumulator sees its widest swing on the sign-bit cycle. The bench builds this by feeding a 32-sample sequence derived from its own coefficient list, in both polarities, and checks the result after the last sample of each sequence. A second hard case is a sample offered while a computation is running. The bench holds `in_valid` high with a distinctive value in the middle of each such computation, and later results are checked against a history that excludes those offers.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

   localparam int NUM_GROUPS = 3;
   localparam int MAX_GROUP  = 8;

   // Coefficients are split into NUM_GROUPS groups; earlier groups take the remainder.
   function automatic int grp_size(input int ncoef, input int g);
      return ncoef / NUM_GROUPS + ((g < (ncoef % NUM_GROUPS)) ? 1 : 0);
   endfunction

   function automatic int grp_base(input int ncoef, input int g);
      int b;
      b = 0;
      for (int i = 0; i < g; i++) b += grp_size(ncoef, i);
      return b;
   endfunction

endpackage

// File: rtl/dafir_taps.sv
module dafir_taps #(
   parameter int DATA_W = 16,
   parameter int TAPS   = 32,
   localparam int NPAIR = TAPS / 2,
   localparam int SUM_W = DATA_W + 1,
   localparam int IDX_W = $clog2(SUM_W)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     shift_en,
   input  logic signed [DATA_W-1:0] din,
   input  logic [IDX_W-1:0]         bit_idx,
   output logic [NPAIR-1:0]         slice
);

   logic signed [DATA_W-1:0] line [TAPS];
   logic signed [SUM_W-1:0]  pair [NPAIR];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < TAPS; i++) line[i] <= '0;
      end else if (shift_en) begin
         line[0] <= din;
         for (int i = 1; i < TAPS; i++) line[i] <= line[i-1];
      end
   end

   for (genvar i = 0; i < NPAIR; i++) begin : g_pair
      assign pair[i]  = SUM_W'(line[i]) + SUM_W'(line[TAPS-1-i]);
      assign slice[i] = pair[i][bit_idx];
   end

   AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> ($stable(line[0]) && $stable(line[TAPS-1]))); // R4

endmodule

// File: rtl/dafir_lut.sv
module dafir_lut #(
   parameter int COEF_W = 12,
   parameter int NCOEF  = 16,
   parameter logic [NCOEF*COEF_W-1:0] COEFS = '0,
   parameter int BASE   = 0,
   parameter int SIZE   = 6,
   parameter int OUT_W  = 17,
   localparam int DEPTH = 1 << SIZE
) (
   input  logic [SIZE-1:0]         addr,
   output logic signed [OUT_W-1:0] val
);

   function automatic logic signed [OUT_W-1:0] entry(input int e);
      logic signed [OUT_W-1:0]  s;
      logic signed [COEF_W-1:0] c;
      s = '0;
      for (int b = 0; b < SIZE; b++) begin
         c = $signed(COEFS[(BASE+b)*COEF_W +: COEF_W]);
         if (((e >> b) & 1) != 0) s = s + OUT_W'(c);
      end
      return s;
   endfunction

   logic signed [OUT_W-1:0] rom [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_rom
      assign rom[e] = entry(e);
   end

   assign val = rom[addr];

endmodule

// File: rtl/dafir_acc.sv
module dafir_acc #(
   parameter int LUT_W = 17,
   parameter int STEPS = 17,
   parameter int ACC_W = 34,
   localparam int CNT_W = $clog2(STEPS)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    start,
   input  logic signed [LUT_W-1:0] part,
   output logic                    busy,
   output logic [CNT_W-1:0]        bit_idx,
   output logic signed [ACC_W-1:0] acc,
   output logic                    done
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

   logic signed [ACC_W-1:0] part_ext, aligned;
   logic                    last;

   assign last     = (bit_idx == LAST);
   assign part_ext = ACC_W'(part);
   assign aligned  = part_ext <<< (STEPS - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy    <= 1'b0;
         bit_idx <= '0;
         acc     <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy    <= 1'b1;
            bit_idx <= '0;
            acc     <= '0;
         end else if (busy) begin
            acc     <= (acc >>> 1) + (last ? -aligned : aligned);
            bit_idx <= bit_idx + CNT_W'(1);
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
      start |=> (busy && bit_idx == '0)); // R2
   AST_FINISH_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
      (busy && last) |=> (done && !busy)); // R2
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R3
   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
      busy |-> !start); // R4

endmodule

// File: rtl/da_symfir.sv
module da_symfir #(
   parameter int DATA_W = 16,
   parameter int COEF_W = 12,
   parameter int TAPS   = 32,
   parameter logic [(TAPS/2)*COEF_W-1:0] COEFS = {
      12'sd6,    -12'sd14,  12'sd23,   -12'sd35,
      12'sd52,   -12'sd77,  12'sd112,  -12'sd160,
      12'sd228,  -12'sd326, 12'sd470,  -12'sd690,
      12'sd1040, 12'sd1500, 12'sd1850, 12'sd2047 },
   localparam int NCOEF = TAPS / 2,
   localparam int SUM_W = DATA_W + 1,
   localparam int LUT_W = COEF_W + $clog2(NCOEF) + 1,
   localparam int ACC_W = LUT_W + SUM_W
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   output logic                     in_ready,
   output logic                     out_valid,
   output logic signed [ACC_W-1:0]  out_data
);

   import dafir_pkg::*;

   localparam int IDX_W = $clog2(SUM_W);

   if (TAPS % 2 != 0) begin : g_err_odd
      $error("TAPS must be even for symmetric pre-addition");
   end
   if (NCOEF < NUM_GROUPS) begin : g_err_few
      $error("too few coefficients for the table split");
   end
   if (grp_size(NCOEF, 0) > MAX_GROUP) begin : g_err_big
      $error("a coefficient group exceeds the table address limit");
   end

   logic                    busy, start;
   logic [IDX_W-1:0]        bit_idx;
   logic [NCOEF-1:0]        slice;
   logic signed [LUT_W-1:0] part [NUM_GROUPS];
   logic signed [LUT_W-1:0] part_sum;

   assign in_ready = !busy;
   assign start    = in_valid && !busy;

   dafir_taps #(.DATA_W(DATA_W), .TAPS(TAPS)) u_taps (
      .clk(clk), .rst(rst), .shift_en(start), .din(in_data),
      .bit_idx(bit_idx), .slice(slice)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam int SZ = grp_size(NCOEF, g);
      localparam int BS = grp_base(NCOEF, g);
      dafir_lut #(
         .COEF_W(COEF_W), .NCOEF(NCOEF), .COEFS(COEFS),
         .BASE(BS), .SIZE(SZ), .OUT_W(LUT_W)
      ) u_lut (
         .addr(slice[BS +: SZ]), .val(part[g])
      );
   end

   always_comb begin
      part_sum = '0;
      for (int g = 0; g < NUM_GROUPS; g++) part_sum = part_sum + part[g];
   end

   dafir_acc #(.LUT_W(LUT_W), .STEPS(SUM_W), .ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst(rst), .start(start), .part(part_sum),
      .busy(busy), .bit_idx(bit_idx), .acc(out_data), .done(out_valid)
   );

   AST_READY_AT_RESULT: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> in_ready); // R5
   AST_READY_AFTER_RESET: assert property (@(posedge clk)
      rst |=> (in_ready && !out_valid)); // R6

endmodule

// File: tb/da_symfir_tb.sv
module da_symfir_tb;

   localparam int H [16] = '{3, -11, 25, -47, 80, -128, 199, -301,
                             455, -700, 1100, -2048, 2047, 1500, -900, 600};

   function automatic logic [191:0] pack_coefs();
      logic [191:0] p;
      p = '0;
      for (int k = 0; k < 16; k++) p[k*12 +: 12] = 12'(H[k]);
      return p;
   endfunction

   localparam logic [191:0] COEF_P = pack_coefs();

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_data = '0;
   logic               in_ready, out_valid;
   logic signed [33:0] out_data;

   int     n_checks = 0;
   int     n_fail   = 0;
   bit     finished = 0;
   longint hist [32];

   always #5 clk = ~clk;

   da_symfir #(.COEFS(COEF_P)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint model();
      longint s;
      s = 0;
      for (int k = 0; k < 16; k++) s += longint'(H[k]) * (hist[k] + hist[31-k]);
      return s;
   endfunction

   // Called at a negedge; returns at the negedge where out_valid is high.
   task automatic send(input logic signed [15:0] x, input bit junk, input string tag);
      int lat;
      chk(in_ready == 1'b1, "R5 ready before accept", longint'(in_ready), 1);
      in_valid = 1'b1;
      in_data  = x;
      @(posedge clk);
      for (int k = 31; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'(x);
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b0, "R3 valid single cycle", longint'(out_valid), 0);
      chk(in_ready == 1'b0, "R4 busy after accept", longint'(in_ready), 0);
      lat = 1;
      while (!out_valid && lat < 40) begin
         if (junk && lat >= 2 && lat < 6) begin
            in_valid = 1'b1;
            in_data  = 16'sh5A5A;
         end else begin
            in_valid = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      in_valid = 1'b0;
      chk(lat == 18, "R2 latency", lat, 18);
      chk(longint'(out_data) == model(), tag, longint'(out_data), model());
      chk(in_ready == 1'b1, "R5 ready with valid", longint'(in_ready), 1);
   endtask

   initial begin
      for (int k = 0; k < 32; k++) hist[k] = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(in_ready == 1'b1, "R6 ready after reset", longint'(in_ready), 1);
      chk(out_valid == 1'b0, "R6 no valid after reset", longint'(out_valid), 0);

      // R1: unit impulse walks through every coefficient
      send(16'sd1, 1'b0, "R1 impulse");
      for (int i = 0; i < 32; i++) send(16'sd0, 1'b1, "R1 impulse tail");

      // R7: full-scale negative impulse and steps
      send(-16'sd32768, 1'b0, "R7 neg impulse");
      for (int i = 0; i < 32; i++) send(16'sd0, 1'b1, "R7 neg impulse tail");
      for (int i = 0; i < 36; i++) send(16'sd32767, 1'b0, "R1 positive step");
      for (int i = 0; i < 36; i++) send(-16'sd32768, 1'b1, "R7 negative step");

      // R7: sign-aligned worst case, both polarities
      for (int pol = 0; pol < 2; pol++) begin
         for (int m = 0; m < 32; m++) begin
            int k;
            logic signed [15:0] v;
            k = (m < 16) ? m : 31 - m;
            if ((H[k] >= 0) == (pol == 0)) v = 16'sd32767;
            else v = -16'sd32768;
            send(v, 1'b0, "R7 extreme magnitude");
         end
      end

      // R1/R4: random samples with junk offered while busy
      for (int i = 0; i < 200; i++) send(16'($urandom), (i % 3) == 0, "R1 random");

      // R6: reset in the middle of a computation
      in_valid = 1'b1;
      in_data  = 16'sd1234;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (5) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 32; k++) hist[k] = 0;
      chk(in_ready == 1'b1, "R6 ready after mid reset", longint'(in_ready), 1);
      begin
         int seen;
         seen = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
         end
         chk(seen == 0, "R6 abandoned computation", seen, 0);
      end
      send(16'sd777, 1'b0, "R6 line cleared");
      for (int i = 0; i < 31; i++) send(16'sd0, 1'b0, "R6 line cleared tail");

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule